// File: doc/BRIEF.md
# Trigger Qualifier and Transfer-Number Lane Multiplexer

This block drives one 4-bit output lane toward a downstream hub. The lane carries one of two things. The first is a group of four level-1 trigger qualifiers, where the top qualifier may be replaced by a hardware-sourced one. The second is one selected nibble of a 16-bit running transfer-number counter. The counter advances once per tick-clock edge on which its increment gate (the send-level-2-decision strobe) is high.

A small control register, reached through a simple address/data register port, holds three settings:
- the counter nibble to send;
- whether the hardware qualifier replaces the top normal qualifier;
- the source mode of the lane.

The source mode can fix the lane to qualifiers, fix it to the counter nibble, or hand the choice to an external timing input on every tick. The hardware qualifier is the OR of eight mark-and-force-pass inputs. The registered lane value can also be read back through the register port for monitoring.

Top module: `qual_xfer_mux`

## Requirements
- R1: On each rising `clk` edge with `rst` low, the 16-bit counter increases by one when `incGate` is 1 and holds its value when `incGate` is 0. It wraps from 0xFFFF to 0x0000.
- R2: When the lane sends the counter, it sends counter bits [4*k+3:4*k], where k is control bits 2:1. So 0 selects 3:0, 1 selects 7:4, 2 selects 11:8 and 3 selects 15:12.
- R3: When control bit 0 is 1 and the lane sends qualifiers, lane bit 3 carries the OR of the eight `hwQual` inputs and lane bits 2:0 carry `normQual[2:0]`. When control bit 0 is 0, the lane carries `normQual[3:0]` unchanged.
- R4: Control bits 4:3 select the lane source:
  - 0 sends qualifiers.
  - 1 sends the counter nibble.
  - 2 sends the counter nibble when `timingSel` is 1 and qualifiers when it is 0.
  - 3 behaves as 0.
- R5: A write with `regWrEn` high to address 48 stores `regWrData[4:0]` as the control value. Reading address 48 returns that value in bits 4:0 with bits 15:5 zero. Writes to any other address change nothing.
- R6: While `rst` is high at a rising `clk` edge, the counter, the control value and the lane are all cleared to zero.
- R7: `laneOut` is registered. It shows, one edge later, the value selected from the inputs, control and counter as they stood before that edge. Reading address 49 returns the current lane in bits 3:0 with the other bits zero. Reading any address other than 48 or 49 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| incGate | input | 1 | Counter increment gate (send-level-2-decision) |
| normQual | input | 4 | Normal level-1 qualifiers |
| hwQual | input | 8 | Mark-and-force-pass inputs, ORed into the hardware qualifier |
| timingSel | input | 1 | Per-tick source choice in mode 2 (1 = counter) |
| regAddr | input | 8 | Register port address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` (combinational) |
| laneOut | output | 4 | Registered output lane |

## Verification
A wrong counter value stays hidden until the lane is switched to counter mode. The bench therefore keeps the lane on a counter nibble through a full 65536-step wrap, and it compares the lane against a behavioural model on every clock. That comparison makes a counter fault visible one edge after it happens. A corrupted control value shows both at the lane, on the next edge, and immediately on a read of address 48. Mode-2 faults are exposed by toggling `timingSel` from cycle to cycle.

// File: rtl/qxm_pkg.sv
package qxm_pkg;
  localparam int CNT_W_D  = 16;
  localparam int LANE_W_D = 4;
  localparam int NIB_N_D  = CNT_W_D / LANE_W_D;
  localparam int SEL_W_D  = $clog2(NIB_N_D);

  typedef enum logic [1:0] {
    MODE_QUAL  = 2'd0,
    MODE_CNT   = 2'd1,
    MODE_TIMED = 2'd2,
    MODE_ALT   = 2'd3
  } laneMode_e;

  typedef struct packed {
    logic               sendCnt;
    logic               hwSubst;
    logic [SEL_W_D-1:0] nibSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/qxm_ctrl.sv
module qxm_ctrl
  import qxm_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 48,
  parameter int MON_ADDR  = 49,
  parameter int LANE_W    = LANE_W_D,
  parameter int SEL_W     = SEL_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              timingSel,
  input  logic [LANE_W-1:0] laneMon,
  output logic [REG_W-1:0]  regRdData,
  output ctrlStrobes_t      ctrlS
);
  localparam int MODE_LO   = SEL_W + 1;
  localparam int CTRL_USED = SEL_W + 3;

  logic [CTRL_USED-1:0] ctrlReg;
  logic                 wrHit;
  laneMode_e            modeSel;

  assign wrHit = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
    end else if (wrHit) begin
      ctrlReg <= regWrData[CTRL_USED-1:0];
    end
  end

  assign modeSel = laneMode_e'(ctrlReg[MODE_LO +: 2]);

  always_comb begin
    ctrlS.hwSubst = ctrlReg[0];
    ctrlS.nibSel  = ctrlReg[SEL_W:1];
    unique case (modeSel)
      MODE_CNT:   ctrlS.sendCnt = 1'b1;
      MODE_TIMED: ctrlS.sendCnt = timingSel;
      default:    ctrlS.sendCnt = 1'b0;
    endcase
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(CTRL_ADDR)) begin
      regRdData[CTRL_USED-1:0] = ctrlReg;
    end else if (regAddr == ADDR_W'(MON_ADDR)) begin
      regRdData[LANE_W-1:0] = laneMon;
    end
  end

  // R5: a write to the control address is stored
  p_ctrl_write_r5: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADDR_W'(CTRL_ADDR)) |=> ctrlReg == $past(regWrData[CTRL_USED-1:0]));

  // R5: writes elsewhere leave the control value alone
  p_ctrl_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && regAddr == ADDR_W'(CTRL_ADDR)) |=> $stable(ctrlReg));

  // R5: unused upper bits read as zero
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (regAddr == ADDR_W'(CTRL_ADDR)) |-> regRdData[REG_W-1:CTRL_USED] == '0);

  // R6: reset clears the control value
  p_ctrl_reset_r6: assert property (@(posedge clk)
    rst |=> ctrlReg == '0);
endmodule

// File: rtl/qxm_datapath.sv
module qxm_datapath
  import qxm_pkg::*;
#(
  parameter int CNT_W  = CNT_W_D,
  parameter int LANE_W = LANE_W_D,
  parameter int HW_N   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              incGate,
  input  logic [LANE_W-1:0] normQual,
  input  logic [HW_N-1:0]   hwQual,
  input  ctrlStrobes_t      ctrlS,
  output logic [LANE_W-1:0] laneOut
);
  localparam int NIB_N = CNT_W / LANE_W;

  logic [CNT_W-1:0]  xferCnt;
  logic [LANE_W-1:0] nibArr [NIB_N];
  logic [LANE_W-1:0] cntNib;
  logic [LANE_W-1:0] qualSel;
  logic [LANE_W-1:0] laneNext;
  logic              hwOr;

  always_ff @(posedge clk) begin
    if (rst) begin
      xferCnt <= '0;
    end else if (incGate) begin
      xferCnt <= xferCnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NIB_N; g++) begin : g_nib
    assign nibArr[g] = xferCnt[g*LANE_W +: LANE_W];
  end

  assign cntNib = nibArr[ctrlS.nibSel];
  assign hwOr   = |hwQual;

  always_comb begin
    qualSel = normQual;
    if (ctrlS.hwSubst) begin
      qualSel[LANE_W-1] = hwOr;
    end
  end

  assign laneNext = ctrlS.sendCnt ? cntNib : qualSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      laneOut <= '0;
    end else begin
      laneOut <= laneNext;
    end
  end

  // R1: gated increment
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    incGate |=> xferCnt == $past(xferCnt) + 1'b1);

  // R1: hold without gate
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !incGate |=> $stable(xferCnt));

  // R3: substituted top qualifier follows the OR of the hardware inputs
  p_hw_subst_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrlS.sendCnt && ctrlS.hwSubst) |=> laneOut[LANE_W-1] == (|$past(hwQual)));

  // R4: qualifier path without substitution passes inputs unchanged
  p_qual_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrlS.sendCnt && !ctrlS.hwSubst) |=> laneOut == $past(normQual));

  // R6: reset clears counter and lane
  p_dp_reset_r6: assert property (@(posedge clk)
    rst |=> (xferCnt == '0 && laneOut == '0));
endmodule

// File: rtl/qual_xfer_mux.sv
module qual_xfer_mux
  import qxm_pkg::*;
#(
  parameter int CNT_W     = CNT_W_D,
  parameter int LANE_W    = LANE_W_D,
  parameter int HW_N      = 8,
  parameter int REG_W     = 16,
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 48,
  parameter int MON_ADDR  = 49
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              incGate,
  input  logic [LANE_W-1:0] normQual,
  input  logic [HW_N-1:0]   hwQual,
  input  logic              timingSel,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic [LANE_W-1:0] laneOut
);
  localparam int SEL_W = $clog2(CNT_W / LANE_W);

  ctrlStrobes_t ctrlS;

  qxm_ctrl #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .MON_ADDR(MON_ADDR), .LANE_W(LANE_W), .SEL_W(SEL_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .timingSel(timingSel), .laneMon(laneOut),
    .regRdData(regRdData), .ctrlS(ctrlS)
  );

  qxm_datapath #(
    .CNT_W(CNT_W), .LANE_W(LANE_W), .HW_N(HW_N)
  ) dp_i (
    .clk(clk), .rst(rst), .incGate(incGate), .normQual(normQual),
    .hwQual(hwQual), .ctrlS(ctrlS), .laneOut(laneOut)
  );
endmodule

// File: tb/qual_xfer_mux_tb.sv
module qual_xfer_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        incGate = 1'b0;
  logic [3:0]  normQual = '0;
  logic [7:0]  hwQual = '0;
  logic        timingSel = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [3:0]  laneOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit live = 1'b0;
  string curReq = "R6";

  // behavioural model state
  int mCnt = 0;
  int mCtrl = 0;
  int mLane = 0;

  always #10 clk = ~clk;

  qual_xfer_mux dut_i (
    .clk(clk), .rst(rst), .incGate(incGate), .normQual(normQual),
    .hwQual(hwQual), .timingSel(timingSel), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .laneOut(laneOut)
  );

  function automatic int modelLane();
    int mode = (mCtrl >> 3) & 3;
    bit useCnt = (mode == 1) || (mode == 2 && timingSel);
    int q;
    if (useCnt) return (mCnt >> (((mCtrl >> 1) & 3) * 4)) & 15;
    q = normQual;
    if (mCtrl & 1) q = (q & 7) | ((hwQual != 0) ? 8 : 0);
    return q;
  endfunction

  function automatic int modelRead();
    if (regAddr == 48) return mCtrl;
    if (regAddr == 49) return mLane;
    return 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mCnt = 0; mCtrl = 0; mLane = 0;
    end else begin
      mLane = modelLane();
      if (incGate) mCnt = (mCnt + 1) % 65536;
      if (regWrEn && regAddr == 48) mCtrl = regWrData & 31;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check({curReq, " lane"}, laneOut, mLane);
      check({curReq, " read"}, regRdData, modelRead());
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
    end
  endtask

  task automatic wr(input int a, input int d);
    regAddr = 8'(a); regWrData = 16'(d); regWrEn = 1'b1;
    tick(1);
    regWrEn = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    live = 1'b1;
    curReq = "R6";
    regAddr = 8'd48; #1 check("R6 ctrl after reset", regRdData, 0);
    check("R6 lane after reset", laneOut, 0);

    curReq = "R5";
    wr(48, 16'hFFFF);
    regAddr = 8'd48; #1 check("R5 upper bits zero", regRdData, 16'h001F);
    wr(50, 16'h0000);
    regAddr = 8'd48; #1 check("R5 other address ignored", regRdData, 16'h001F);
    regAddr = 8'd51; #1 check("R7 unmapped read zero", regRdData, 0);
    wr(48, 0);

    curReq = "R1";
    wr(48, 5'b01_11_0);
    incGate = 1'b1; tick(20);
    incGate = 1'b0; tick(5);
    for (int i = 0; i < 12; i++) begin
      incGate = i[0]; tick(1);
    end
    incGate = 1'b1; tick(65536);
    incGate = 1'b0; tick(2);

    curReq = "R2";
    for (int k = 0; k < 4; k++) begin
      wr(48, (1 << 3) | (k << 1));
      incGate = 1'b1; tick(40); incGate = 1'b0; tick(2);
    end

    curReq = "R3";
    wr(48, 1);
    for (int p = 0; p < 16; p++) begin
      normQual = 4'(p); hwQual = (p % 3 == 0) ? 8'h00 : 8'(1 << (p % 8)); tick(1);
    end
    wr(48, 0);
    normQual = 4'h7; hwQual = 8'hFF; tick(2);
    check("R3 no substitution", laneOut, 7);

    curReq = "R4";
    incGate = 1'b1;
    for (int m = 0; m < 4; m++) begin
      wr(48, (m << 3) | 1);
      for (int t = 0; t < 10; t++) begin
        timingSel = t[0] ^ t[2]; normQual = 4'(t * 5); hwQual = 8'(t & 2); tick(1);
      end
    end
    incGate = 1'b0;

    curReq = "R7";
    wr(48, 0);
    normQual = 4'hA; tick(1);
    regAddr = 8'd49; #1 check("R7 lane readback", regRdData, 16'h000A);
    normQual = 4'h5; #1 check("R7 lane not yet changed", laneOut, 4'hA);
    tick(1);
    check("R7 lane one edge later", laneOut, 4'h5);

    curReq = "R6";
    wr(48, 5'b01_10_1); incGate = 1'b1; tick(3);
    rst = 1'b1; tick(1); rst = 1'b0; incGate = 1'b0;
    regAddr = 8'd48; #1 check("R6 ctrl cleared", regRdData, 0);
    check("R6 lane cleared", laneOut, 0);
    wr(48, 5'b01_00_0); tick(1);
    check("R6 counter cleared", laneOut, 0);

    live = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule